// File: doc/BRIEF.md
# DSP Accumulator Register File

This block is the operand store of a fixed-point DSP datapath. It holds eight data registers: two 40-bit accumulators whose top eight bits act as guard bits against overflow, and six 32-bit registers. It also holds one plain 32-bit status word. Two ALU read ports always return 40-bit operands. Values from the 32-bit registers come out sign-extended to that width. One ALU write port accepts a 40-bit result. A write to a 32-bit register keeps only the low 32 bits of that result.

Each of the two memory sides (X and Y) has its own 16-bit path for loads and stores. A transfer always moves the upper halfword (bits 31..16) of a register. A load clears the lower halfword in the same cycle. Only certain registers may take part in a transfer. A request naming any other register is refused, and the refusal is reported on a one-cycle error flag.

Top module: `dsp_regbank`

## Requirements
- R1: Register indices are 3 bits: A0=0, A1=1, X0=2, X1=3, Y0=4, Y1=5, M0=6, M1=7. A synchronous active-high reset clears all eight data registers, guard bits included, and also clears the status word and the error flag.
- R2: A read of index 0 or 1 returns all 40 stored bits of that accumulator, guard bits included.
- R3: A read of index 2..7 returns the 32-bit register in bits 31..0. Its bit 31 is copied into bits 39..32.
- R4: An ALU write to index 0 or 1 stores all 40 bits of the write data.
- R5: An ALU write to index 2..7 stores bits 31..0 of the write data and drops bits 39..32.
- R6: An X load is legal only for index 2 or 3. It places the 16-bit data in bits 31..16 and zeroes bits 15..0 at the same clock edge.
- R7: A Y load is legal only for index 4 or 5. It places the 16-bit data in bits 31..16 and zeroes bits 15..0 at the same clock edge.
- R8: A store on either side is legal only for index 0 or 1. Its data is bits 31..16 of that accumulator, available combinationally in the same cycle. An illegal store drives zero.
- R9: Any illegal load or store request raises the error flag for exactly the cycle after the request. An illegal load changes no register.
- R10: An X load, a Y load and an ALU write may all occur in one cycle. When the ALU write and a load name the same register, the ALU write is stored.
- R11: The status word is written whole when its write enable is high. Its stored value is always visible on the status output.
- R12: Reads and store data reflect contents from before the clock edge. A write becomes visible in the cycle after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 40 | Read port A operand |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 40 | Read port B operand |
| wr_en | input | 1 | ALU write enable |
| wr_idx | input | 3 | ALU write register index |
| wr_data | input | 40 | ALU result |
| xld_en | input | 1 | X-side load request |
| xld_idx | input | 3 | X-side load destination |
| xld_data | input | 16 | X-side load halfword |
| yld_en | input | 1 | Y-side load request |
| yld_idx | input | 3 | Y-side load destination |
| yld_data | input | 16 | Y-side load halfword |
| xst_en | input | 1 | X-side store request |
| xst_idx | input | 3 | X-side store source |
| xst_data | output | 16 | X-side store halfword |
| yst_en | input | 1 | Y-side store request |
| yst_idx | input | 3 | Y-side store source |
| yst_data | output | 16 | Y-side store halfword |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 32 | Status word write data |
| stat_q | output | 32 | Status word contents |
| xfer_err | output | 1 | Illegal transfer flag, one cycle |

## Verification
The bench builds the block with its default widths: a 32-bit word, an 8-bit guard field and 16-bit halfwords. With these widths, directed constants can set bit 31 and bit 15 independently. That makes the sign copy into the guard field, the clearing of the low half and the dropping of result guard bits each visible on their own. Random traffic at these widths mixes legal and illegal indices on all four transfer paths together with ALU writes. This reaches same-register collisions between the ALU write and both load sides, as well as resets in the middle of a run.

// File: rtl/dsp_regbank_pkg.sv
package dsp_regbank_pkg;

   localparam int unsigned IDX_W = 3;
   localparam int unsigned NREG  = 8;
   localparam int unsigned NACC  = 2;

   typedef logic [IDX_W-1:0] ridx_t;

   // Index encoding; transfer legality depends on these values
   localparam ridx_t IDX_A0 = 3'd0;
   localparam ridx_t IDX_A1 = 3'd1;
   localparam ridx_t IDX_X0 = 3'd2;
   localparam ridx_t IDX_X1 = 3'd3;
   localparam ridx_t IDX_Y0 = 3'd4;
   localparam ridx_t IDX_Y1 = 3'd5;
   localparam ridx_t IDX_M0 = 3'd6;
   localparam ridx_t IDX_M1 = 3'd7;

   function automatic logic idx_is_acc(ridx_t i);
      return (i == IDX_A0) || (i == IDX_A1);
   endfunction

   function automatic logic idx_x_dest(ridx_t i);
      return (i == IDX_X0) || (i == IDX_X1);
   endfunction

   function automatic logic idx_y_dest(ridx_t i);
      return (i == IDX_Y0) || (i == IDX_Y1);
   endfunction

endpackage

// File: rtl/dsp_regbank_xfer.sv
module dsp_regbank_xfer
   import dsp_regbank_pkg::*;
(
   input  logic  xld_en,
   input  ridx_t xld_idx,
   input  logic  yld_en,
   input  ridx_t yld_idx,
   input  logic  xst_en,
   input  ridx_t xst_idx,
   input  logic  yst_en,
   input  ridx_t yst_idx,
   output logic  xld_ok,
   output logic  yld_ok,
   output logic  xst_ok,
   output logic  yst_ok,
   output logic  any_bad
);

   always_comb begin
      xld_ok  = xld_en && idx_x_dest(xld_idx);
      yld_ok  = yld_en && idx_y_dest(yld_idx);
      xst_ok  = xst_en && idx_is_acc(xst_idx);
      yst_ok  = yst_en && idx_is_acc(yst_idx);
      any_bad = (xld_en && !xld_ok) || (yld_en && !yld_ok) ||
                (xst_en && !xst_ok) || (yst_en && !yst_ok);
   end

endmodule

// File: rtl/dsp_regbank_cell.sv
module dsp_regbank_cell #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned GUARD_W = 8,
   parameter bit          IS_ACC  = 1'b0,
   localparam int unsigned HALF_W  = WORD_W / 2,
   localparam int unsigned STORE_W = IS_ACC ? (WORD_W + GUARD_W) : WORD_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               alu_we,
   input  logic [STORE_W-1:0] alu_d,
   input  logic               ld_we,
   input  logic [HALF_W-1:0]  ld_d,
   output logic [STORE_W-1:0] q
);

   logic [STORE_W-1:0] r;

   generate
      if (IS_ACC) begin : g_wide
         always_ff @(posedge clk) begin
            if (rst)         r <= '0;
            else if (alu_we) r <= alu_d;
            else if (ld_we)  r <= {r[STORE_W-1:WORD_W], ld_d, {HALF_W{1'b0}}};
         end
      end else begin : g_narrow
         always_ff @(posedge clk) begin
            if (rst)         r <= '0;
            else if (alu_we) r <= alu_d;
            else if (ld_we)  r <= {ld_d, {HALF_W{1'b0}}};
         end
      end
   endgenerate

   assign q = r;

endmodule

// File: rtl/dsp_regbank_rdext.sv
module dsp_regbank_rdext
   import dsp_regbank_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned GUARD_W = 8,
   localparam int unsigned FULL_W = WORD_W + GUARD_W
) (
   input  ridx_t             idx,
   input  logic [FULL_W-1:0] regs [NREG],
   output logic [FULL_W-1:0] data
);

   logic [FULL_W-1:0] raw;

   always_comb begin
      raw = regs[idx];
      if (idx_is_acc(idx)) data = raw;
      else                 data = {{GUARD_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
   end

endmodule

// File: rtl/dsp_regbank.sv
module dsp_regbank
   import dsp_regbank_pkg::*;
#(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned GUARD_W = 8,
   localparam int unsigned FULL_W = WORD_W + GUARD_W,
   localparam int unsigned HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        rd_a_idx,
   output logic [FULL_W-1:0] rd_a_data,
   input  logic [2:0]        rd_b_idx,
   output logic [FULL_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [2:0]        wr_idx,
   input  logic [FULL_W-1:0] wr_data,
   input  logic              xld_en,
   input  logic [2:0]        xld_idx,
   input  logic [HALF_W-1:0] xld_data,
   input  logic              yld_en,
   input  logic [2:0]        yld_idx,
   input  logic [HALF_W-1:0] yld_data,
   input  logic              xst_en,
   input  logic [2:0]        xst_idx,
   output logic [HALF_W-1:0] xst_data,
   input  logic              yst_en,
   input  logic [2:0]        yst_idx,
   output logic [HALF_W-1:0] yst_data,
   input  logic              stat_we,
   input  logic [31:0]       stat_wdata,
   output logic [31:0]       stat_q,
   output logic              xfer_err
);

   localparam int unsigned NRD = 2;

   generate
      if (WORD_W % 2 != 0) begin : g_chk_even
         $error("WORD_W must be even");
      end
      if (GUARD_W < 1) begin : g_chk_guard
         $error("GUARD_W must be at least one");
      end
      if (NREG != (1 << IDX_W)) begin : g_chk_nreg
         $error("register count must fill the index space");
      end
   endgenerate

   logic [FULL_W-1:0] reg_q [NREG];
   logic [NREG-1:0]   alu_we;
   logic [NREG-1:0]   ld_we;
   logic [HALF_W-1:0] ld_d [NREG];
   logic xld_ok, yld_ok, xst_ok, yst_ok, any_bad;
   logic err_q;
   logic [31:0] stat_r;

   dsp_regbank_xfer u_xfer (
      .xld_en  (xld_en),
      .xld_idx (xld_idx),
      .yld_en  (yld_en),
      .yld_idx (yld_idx),
      .xst_en  (xst_en),
      .xst_idx (xst_idx),
      .yst_en  (yst_en),
      .yst_idx (yst_idx),
      .xld_ok  (xld_ok),
      .yld_ok  (yld_ok),
      .xst_ok  (xst_ok),
      .yst_ok  (yst_ok),
      .any_bad (any_bad)
   );

   // Per-register write steering; the cell gives the ALU port priority
   always_comb begin
      for (int k = 0; k < NREG; k++) begin
         alu_we[k] = wr_en && (wr_idx == IDX_W'(k));
         ld_we[k]  = (xld_ok && (xld_idx == IDX_W'(k))) ||
                     (yld_ok && (yld_idx == IDX_W'(k)));
         ld_d[k]   = (xld_ok && (xld_idx == IDX_W'(k))) ? xld_data : yld_data;
      end
   end

   generate
      for (genvar k = 0; k < NREG; k++) begin : g_reg
         if (k < NACC) begin : g_acc
            logic [FULL_W-1:0] q;
            dsp_regbank_cell #(
               .WORD_W  (WORD_W),
               .GUARD_W (GUARD_W),
               .IS_ACC  (1'b1)
            ) u_cell (
               .clk    (clk),
               .rst    (rst),
               .alu_we (alu_we[k]),
               .alu_d  (wr_data),
               .ld_we  (ld_we[k]),
               .ld_d   (ld_d[k]),
               .q      (q)
            );
            assign reg_q[k] = q;
         end else begin : g_plain
            logic [WORD_W-1:0] q;
            dsp_regbank_cell #(
               .WORD_W  (WORD_W),
               .GUARD_W (GUARD_W),
               .IS_ACC  (1'b0)
            ) u_cell (
               .clk    (clk),
               .rst    (rst),
               .alu_we (alu_we[k]),
               .alu_d  (wr_data[WORD_W-1:0]),
               .ld_we  (ld_we[k]),
               .ld_d   (ld_d[k]),
               .q      (q)
            );
            assign reg_q[k] = {{GUARD_W{1'b0}}, q};
         end
      end

      for (genvar p = 0; p < NRD; p++) begin : g_rd
         ridx_t             idx;
         logic [FULL_W-1:0] data;
         if (p == 0) begin : g_a
            assign idx       = rd_a_idx;
            assign rd_a_data = data;
         end else begin : g_b
            assign idx       = rd_b_idx;
            assign rd_b_data = data;
         end
         dsp_regbank_rdext #(
            .WORD_W  (WORD_W),
            .GUARD_W (GUARD_W)
         ) u_rd (
            .idx  (idx),
            .regs (reg_q),
            .data (data)
         );
      end
   endgenerate

   assign xst_data = xst_ok ? reg_q[xst_idx][WORD_W-1:HALF_W] : '0;
   assign yst_data = yst_ok ? reg_q[yst_idx][WORD_W-1:HALF_W] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         err_q  <= 1'b0;
         stat_r <= '0;
      end else begin
         err_q <= any_bad;
         if (stat_we) stat_r <= stat_wdata;
      end
   end

   assign xfer_err = err_q;
   assign stat_q   = stat_r;

endmodule

// File: rtl/dsp_regbank_chk.sv
module dsp_regbank_chk #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned GUARD_W = 8,
   localparam int unsigned FULL_W = WORD_W + GUARD_W,
   localparam int unsigned HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        rd_a_idx,
   input logic [FULL_W-1:0] rd_a_data,
   input logic              wr_en,
   input logic [2:0]        wr_idx,
   input logic [FULL_W-1:0] wr_data,
   input logic              xld_en,
   input logic [2:0]        xld_idx,
   input logic [HALF_W-1:0] xld_data,
   input logic              yld_en,
   input logic              xst_en,
   input logic [2:0]        xst_idx,
   input logic [HALF_W-1:0] xst_data,
   input logic              yst_en,
   input logic              xfer_err,
   input logic [FULL_W-1:0] reg_q [8]
);

   p_acc_read_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == 3'd0) |-> (rd_a_data == reg_q[0]));

   p_sext_read_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx >= 3'd2) |->
         (rd_a_data[FULL_W-1:WORD_W] == {GUARD_W{rd_a_data[WORD_W-1]}}) &&
         (rd_a_data[WORD_W-1:0] == reg_q[rd_a_idx][WORD_W-1:0]));

   p_acc_write_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == 3'd1) |=> (reg_q[1] == $past(wr_data)));

   p_xload_r6: assert property (@(posedge clk) disable iff (rst)
      (xld_en && xld_idx == 3'd2 && !(wr_en && wr_idx == 3'd2)) |=>
         (reg_q[2][WORD_W-1:0] == {$past(xld_data), {HALF_W{1'b0}}}));

   p_store_r8: assert property (@(posedge clk) disable iff (rst)
      (xst_en && xst_idx == 3'd1) |-> (xst_data == reg_q[1][WORD_W-1:HALF_W]));

   p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
      (xld_en && xld_idx != 3'd2 && xld_idx != 3'd3) |=> xfer_err);

   p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (!xld_en && !yld_en && !xst_en && !yst_en) |=> !xfer_err);

   p_alu_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == 3'd3 && xld_en && xld_idx == 3'd3) |=>
         (reg_q[3][WORD_W-1:0] == $past(wr_data[WORD_W-1:0])));

endmodule

bind dsp_regbank dsp_regbank_chk #(
   .WORD_W  (WORD_W),
   .GUARD_W (GUARD_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rd_a_idx  (rd_a_idx),
   .rd_a_data (rd_a_data),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .xld_en    (xld_en),
   .xld_idx   (xld_idx),
   .xld_data  (xld_data),
   .yld_en    (yld_en),
   .xst_en    (xst_en),
   .xst_idx   (xst_idx),
   .xst_data  (xst_data),
   .yst_en    (yst_en),
   .xfer_err  (xfer_err),
   .reg_q     (reg_q)
);

// File: tb/dsp_regbank_test.sv
module dsp_regbank_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  rd_a_idx, rd_b_idx, wr_idx, xld_idx, yld_idx, xst_idx, yst_idx;
   logic [39:0] rd_a_data, rd_b_data, wr_data;
   logic        wr_en, xld_en, yld_en, xst_en, yst_en, stat_we;
   logic [15:0] xld_data, yld_data, xst_data, yst_data;
   logic [31:0] stat_wdata, stat_q;
   logic        xfer_err;

   int n_total = 0;
   int n_bad   = 0;
   bit done    = 1'b0;

   logic [39:0] m [8];
   logic [31:0] sm;

   always #5 clk = ~clk;

   dsp_regbank uut (
      .clk(clk), .rst(rst),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .xld_en(xld_en), .xld_idx(xld_idx), .xld_data(xld_data),
      .yld_en(yld_en), .yld_idx(yld_idx), .yld_data(yld_data),
      .xst_en(xst_en), .xst_idx(xst_idx), .xst_data(xst_data),
      .yst_en(yst_en), .yst_idx(yst_idx), .yst_data(yst_data),
      .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
      .xfer_err(xfer_err)
   );

   task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R3: guard field of a 32-bit register copies bit 31
   function automatic logic [39:0] ext(logic [2:0] i);
      if (i < 3'd2) return m[i];
      return {{8{m[i][31]}}, m[i][31:0]};
   endfunction

   function automatic logic [15:0] st_exp(logic en, logic [2:0] i);
      if (en && i < 3'd2) return m[i][31:16];
      return 16'h0;
   endfunction

   task automatic idle();
      rst = 1'b0; wr_en = 1'b0; xld_en = 1'b0; yld_en = 1'b0;
      xst_en = 1'b0; yst_en = 1'b0; stat_we = 1'b0;
      wr_idx = '0; xld_idx = '0; yld_idx = '0; xst_idx = '0; yst_idx = '0;
      rd_a_idx = '0; rd_b_idx = '0; wr_data = '0; xld_data = '0;
      yld_data = '0; stat_wdata = '0;
   endtask

   // Inputs are set at a falling edge before this is called
   task automatic run_cycle();
      logic [39:0] nm [8];
      logic        bad;
      logic        xok, yok;
      #2;
      chk(rd_a_idx < 3'd2 ? "R2 port a" : "R3 port a", rd_a_data, ext(rd_a_idx));
      chk(rd_b_idx < 3'd2 ? "R2 port b" : "R3 port b", rd_b_data, ext(rd_b_idx));
      chk("R8 x store", {24'h0, xst_data}, {24'h0, st_exp(xst_en, xst_idx)});
      chk("R8 y store", {24'h0, yst_data}, {24'h0, st_exp(yst_en, yst_idx)});
      chk("R11 status", {8'h0, stat_q}, {8'h0, sm});
      xok = xld_en && (xld_idx == 3'd2 || xld_idx == 3'd3);
      yok = yld_en && (yld_idx == 3'd4 || yld_idx == 3'd5);
      bad = (xld_en && !xok) || (yld_en && !yok) ||
            (xst_en && xst_idx > 3'd1) || (yst_en && yst_idx > 3'd1);
      for (int k = 0; k < 8; k++) begin
         nm[k] = m[k];
         if (rst) nm[k] = '0;
         else if (wr_en && wr_idx == 3'(k))
            nm[k] = (k < 2) ? wr_data : {8'h0, wr_data[31:0]};
         else if (xok && xld_idx == 3'(k)) nm[k] = {8'h0, xld_data, 16'h0};
         else if (yok && yld_idx == 3'(k)) nm[k] = {8'h0, yld_data, 16'h0};
      end
      if (rst) bad = 1'b0;
      @(posedge clk);
      #1;
      for (int k = 0; k < 8; k++) m[k] = nm[k];
      if (rst) sm = '0;
      else if (stat_we) sm = stat_wdata;
      @(negedge clk);
      chk("R9 error flag", {39'h0, xfer_err}, {39'h0, bad});
   endtask

   task automatic read_now(logic [2:0] i, logic [39:0] exp, string tag);
      rd_a_idx = i;
      #1;
      chk(tag, rd_a_data, exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_total++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int k = 0; k < 8; k++) m[k] = '0;
      sm = '0;
      idle();
      rst = 1'b1;
      // Start the checked cycles on a falling edge
      @(negedge clk);
      run_cycle();
      run_cycle();

      // R1: all registers and the status word read zero after reset
      idle();
      for (int k = 0; k < 8; k++) read_now(3'(k), 40'h0, "R1 reset register");
      chk("R1 reset status", {8'h0, stat_q}, 40'h0);
      chk("R1 reset error flag", {39'h0, xfer_err}, 40'h0);

      // R4, R12: full-width accumulator write; old value seen during write
      idle();
      wr_en = 1'b1; wr_idx = 3'd0; wr_data = 40'hA5_CAFE_1234;
      stat_we = 1'b1; stat_wdata = 32'h1357_9BDF;
      read_now(3'd0, 40'h0, "R12 read before edge");
      run_cycle();
      idle();
      read_now(3'd0, 40'hA5_CAFE_1234, "R4 accumulator write");
      chk("R11 status write", {8'h0, stat_q}, {8'h0, 32'h1357_9BDF});

      // R5, R3: guard bits dropped, then regenerated from bit 31
      wr_en = 1'b1; wr_idx = 3'd2; wr_data = 40'h12_8000_0001;
      run_cycle();
      idle();
      wr_en = 1'b1; wr_idx = 3'd7; wr_data = 40'h80_7FFF_FFFF;
      run_cycle();
      idle();
      read_now(3'd2, 40'hFF_8000_0001, "R5 R3 negative plain register");
      read_now(3'd7, 40'h00_7FFF_FFFF, "R5 R3 positive plain register");

      // R6: X load into X1 replaces the top half and clears the low half
      wr_en = 1'b1; wr_idx = 3'd3; wr_data = 40'h00_1234_5678;
      run_cycle();
      idle();
      xld_en = 1'b1; xld_idx = 3'd3; xld_data = 16'hBEEF;
      run_cycle();
      idle();
      read_now(3'd3, 40'hFF_BEEF_0000, "R6 x load");

      // R7: Y load into Y0
      yld_en = 1'b1; yld_idx = 3'd4; yld_data = 16'h1234;
      run_cycle();
      idle();
      read_now(3'd4, 40'h00_1234_0000, "R7 y load");

      // R9: X load aimed at Y0 is refused; Y0 unchanged, flag pulses once
      xld_en = 1'b1; xld_idx = 3'd4; xld_data = 16'hDEAD;
      run_cycle();
      chk("R9 flag raised", {39'h0, xfer_err}, 40'h1);
      idle();
      read_now(3'd4, 40'h00_1234_0000, "R9 illegal load ignored");
      run_cycle();
      chk("R9 flag cleared", {39'h0, xfer_err}, 40'h0);

      // R8: stores from A0 and an illegal Y store
      idle();
      xst_en = 1'b1; xst_idx = 3'd0; yst_en = 1'b1; yst_idx = 3'd6;
      #1;
      chk("R8 x store from A0", {24'h0, xst_data}, 40'h0_0000_CAFE);
      chk("R8 illegal store zero", {24'h0, yst_data}, 40'h0);
      run_cycle();
      chk("R8 R9 illegal store flag", {39'h0, xfer_err}, 40'h1);

      // R10: three writes in one cycle, ALU wins on Y1
      idle();
      wr_en = 1'b1; wr_idx = 3'd5; wr_data = 40'hFF_0000_0042;
      yld_en = 1'b1; yld_idx = 3'd5; yld_data = 16'h7777;
      xld_en = 1'b1; xld_idx = 3'd2; xld_data = 16'h1111;
      run_cycle();
      idle();
      read_now(3'd5, 40'h00_0000_0042, "R10 ALU wins");
      read_now(3'd2, 40'h00_1111_0000, "R10 concurrent x load");

      // Random traffic with occasional resets
      for (int n = 0; n < 4000; n++) begin
         idle();
         rst        = ($urandom % 250) == 0;
         rd_a_idx   = 3'($urandom);
         rd_b_idx   = 3'($urandom);
         wr_en      = ($urandom % 3) == 0;
         wr_idx     = 3'($urandom);
         wr_data    = {8'($urandom), 32'($urandom)};
         xld_en     = ($urandom % 3) == 0;
         xld_idx    = (($urandom % 4) == 0) ? 3'($urandom) : 3'(2 + $urandom % 2);
         xld_data   = 16'($urandom);
         yld_en     = ($urandom % 3) == 0;
         yld_idx    = (($urandom % 4) == 0) ? 3'($urandom) : 3'(4 + $urandom % 2);
         yld_data   = 16'($urandom);
         xst_en     = ($urandom % 4) == 0;
         xst_idx    = (($urandom % 4) == 0) ? 3'($urandom) : 3'($urandom % 2);
         yst_en     = ($urandom % 4) == 0;
         yst_idx    = (($urandom % 4) == 0) ? 3'($urandom) : 3'($urandom % 2);
         stat_we    = ($urandom % 5) == 0;
         stat_wdata = $urandom;
         run_cycle();
      end

      // R1: reset in mid-run clears everything again
      idle();
      rst = 1'b1;
      run_cycle();
      idle();
      for (int k = 0; k < 8; k++) read_now(3'(k), 40'h0, "R1 late reset");
      chk("R1 late reset status", {8'h0, stat_q}, 40'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule